// File: doc/BRIEF.md
# Complementary PWM Timer with Dead-Time Insertion

This block is a 12-bit up-counting PWM timer for driving the two gates of a half bridge. A prescaler slows the count clock by a factor of 1 to 8. Each PWM cycle has two gate outputs, `hs1_o` and `hs2_o`, whose edges are staggered by a programmable dead time. When the outputs turn on, `hs1_o` rises first. When they turn off, `hs2_o` falls first. A third output, `strobe_o`, rises partway through each cycle and can fire a one-cycle pulse that starts an external ADC conversion.

Software programs the block over a byte-wide register port. It writes the period, compare A, compare B, dead time and a control byte. The period and compare values are staged: a write made while the counter runs takes effect only at the next counter overflow. A read returns the last value written.

In capture mode the HS2 pin becomes an input. The counter then runs freely over its full range. A selected edge on the pin copies the current count into the period register, where software can read it.

Top module: `dtpwm_timer`

## Requirements
- R1: After reset the control byte reads 0x00, the period and both compare registers read 0xFFF, the dead-time register reads 0x1F, and every output except `hs2_oe_o` is low.
- R2: The registers sit at these addresses:
  - 0: control.
  - 1 and 2: period low byte and high nibble.
  - 3 and 4: compare A low byte and high nibble.
  - 5 and 6: compare B low byte and high nibble.
  - 7: dead time in bits 4:0.
  
  Each 12-bit value is {high nibble, low byte}. A read returns the last value written, zero-extended, in the cycle after the address is presented.
- R3: With the timer running in PWM mode, the counter counts from 0 up to the period value P and then returns to 0. Successive rising edges of `hs1_o` are therefore (P+1) count ticks apart.
- R4: Control bits 6:4 hold a prescale code N. One count tick lasts N+1 clock cycles.
- R5: When the count equals compare A, `hs1_o` rises. `hs2_o` rises D clock cycles later, where D is the dead-time value. With D = 0 both outputs rise in the same cycle.
- R6: When the count equals the period value, `hs2_o` falls. `hs1_o` falls D clock cycles later. With D = 0 both outputs fall in the same cycle.
- R7: Period and compare writes made while running leave the cycle in progress unchanged. The values present at the overflow govern the following cycle.
- R8: `strobe_o` rises when the count equals compare B. It falls at the counter overflow.
- R9: When control bit 3 is set, `adc_trig_o` pulses high for exactly one clock cycle, in the cycle `strobe_o` rises. When the bit is clear, the pulse is never produced.
- R10: A write to the dead-time register while control bit 0 (run) is set leaves its value unchanged.
- R11: While run is clear, the counter is held at 0. Within two cycles of run clearing, `hs1_o`, `hs2_o` and `strobe_o` are low.
- R12: Control bit 1 selects capture mode. In this mode:
  - `hs2_oe_o` and `hs2_o` are low and the counter wraps at 0xFFF.
  - An edge on `hs2_i` loads the count into the period register. Control bit 2 selects the edge: 1 for rising, 0 for falling.
  - The opposite edge changes nothing.
  - The difference between two captured values equals the number of clock cycles between the two edges, modulo 4096, when the prescale code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for both reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for `bus_addr` |
| hs2_i | input | 1 | HS2 pin input, used in capture mode |
| hs1_o | output | 1 | First gate output |
| hs2_o | output | 1 | Second gate output |
| hs2_oe_o | output | 1 | Output enable for the HS2 pin, low in capture mode |
| strobe_o | output | 1 | Conversion strobe |
| adc_trig_o | output | 1 | One-cycle ADC start pulse |

## Verification
The assertions assume the following about the inputs:
- Software changes the mode bit only while run is clear.
- Compare A plus the dead time stays below the period.
- Compare B stays below the period.

If these hold, the gate sequencer never sees an off event before it has finished turning on. The counter also never runs past the active period.

The stimulus keeps within these limits. It uses a period of 40 or 60, compare values of 10 and 20, and dead times of 0 or 3. It stops the timer before every mode, prescale or dead-time change.

// File: rtl/dtpwm_pkg.sv
package dtpwm_pkg;
  localparam int BUS_AW = 3;
  localparam logic [BUS_AW-1:0] A_CTRL   = 3'd0;
  localparam logic [BUS_AW-1:0] A_PER_LO = 3'd1;
  localparam logic [BUS_AW-1:0] A_PER_HI = 3'd2;
  localparam logic [BUS_AW-1:0] A_CA_LO  = 3'd3;
  localparam logic [BUS_AW-1:0] A_CA_HI  = 3'd4;
  localparam logic [BUS_AW-1:0] A_CB_LO  = 3'd5;
  localparam logic [BUS_AW-1:0] A_CB_HI  = 3'd6;
  localparam logic [BUS_AW-1:0] A_DEAD   = 3'd7;

  typedef enum logic [1:0] {
    SQ_OFF  = 2'd0,
    SQ_LEAD = 2'd1,
    SQ_ON   = 2'd2,
    SQ_LAG  = 2'd3
  } seq_e;
endpackage

// File: rtl/dtpwm_regs.sv
module dtpwm_regs #(
  parameter int CNT_W = 12,
  parameter int DT_W  = 5,
  parameter int PS_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic [2:0]         bus_addr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic               cap_load,
  input  logic [CNT_W-1:0]   cap_value,
  output logic               run,
  output logic               cap_mode,
  output logic               cap_rise,
  output logic               trig_en,
  output logic [PS_W-1:0]    ps,
  output logic [CNT_W-1:0]   per_w,
  output logic [CNT_W-1:0]   cmpa_w,
  output logic [CNT_W-1:0]   cmpb_w,
  output logic [DT_W-1:0]    dt
);
  import dtpwm_pkg::*;

  localparam int HI_W   = CNT_W - 8;
  localparam int CTRL_W = 4 + PS_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  per_q, cmpa_q, cmpb_q;
  logic [DT_W-1:0]   dt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      per_q  <= '1;
      cmpa_q <= '1;
      cmpb_q <= '1;
      dt_q   <= '1;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_CTRL:   ctrl_q <= bus_wdata[CTRL_W-1:0];
          A_PER_LO: per_q[7:0] <= bus_wdata;
          A_PER_HI: per_q[CNT_W-1:8] <= bus_wdata[HI_W-1:0];
          A_CA_LO:  cmpa_q[7:0] <= bus_wdata;
          A_CA_HI:  cmpa_q[CNT_W-1:8] <= bus_wdata[HI_W-1:0];
          A_CB_LO:  cmpb_q[7:0] <= bus_wdata;
          A_CB_HI:  cmpb_q[CNT_W-1:8] <= bus_wdata[HI_W-1:0];
          default:  if (!ctrl_q[0]) dt_q <= bus_wdata[DT_W-1:0];
        endcase
      end
      if (cap_load) per_q <= cap_value;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        A_CTRL:   bus_rdata <= 8'(ctrl_q);
        A_PER_LO: bus_rdata <= per_q[7:0];
        A_PER_HI: bus_rdata <= 8'(per_q[CNT_W-1:8]);
        A_CA_LO:  bus_rdata <= cmpa_q[7:0];
        A_CA_HI:  bus_rdata <= 8'(cmpa_q[CNT_W-1:8]);
        A_CB_LO:  bus_rdata <= cmpb_q[7:0];
        A_CB_HI:  bus_rdata <= 8'(cmpb_q[CNT_W-1:8]);
        default:  bus_rdata <= 8'(dt_q);
      endcase
    end
  end

  assign run      = ctrl_q[0];
  assign cap_mode = ctrl_q[1];
  assign cap_rise = ctrl_q[2];
  assign trig_en  = ctrl_q[3];
  assign ps       = ctrl_q[CTRL_W-1:4];
  assign per_w    = per_q;
  assign cmpa_w   = cmpa_q;
  assign cmpb_w   = cmpb_q;
  assign dt       = dt_q;
endmodule

// File: rtl/dtpwm_counter.sv
module dtpwm_counter #(
  parameter int CNT_W = 12,
  parameter int PS_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             cap_mode,
  input  logic             trig_en,
  input  logic [PS_W-1:0]  ps,
  input  logic [CNT_W-1:0] per_w,
  input  logic [CNT_W-1:0] cmpa_w,
  input  logic [CNT_W-1:0] cmpb_w,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] per_act,
  output logic             evt_on,
  output logic             evt_off,
  output logic             strobe_o,
  output logic             adc_trig_o
);
  logic [PS_W-1:0]  pre_q;
  logic [CNT_W-1:0] cmpa_act, cmpb_act;
  logic             tick, wrap;

  assign tick    = run && (pre_q == ps);
  assign wrap    = tick && (cap_mode ? (cnt == '1) : (cnt == per_act));
  assign evt_on  = tick && !wrap && (cnt == cmpa_act);
  assign evt_off = wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q      <= '0;
      cnt        <= '0;
      per_act    <= '1;
      cmpa_act   <= '1;
      cmpb_act   <= '1;
      strobe_o   <= 1'b0;
      adc_trig_o <= 1'b0;
    end else if (!run) begin
      pre_q      <= '0;
      cnt        <= '0;
      per_act    <= per_w;
      cmpa_act   <= cmpa_w;
      cmpb_act   <= cmpb_w;
      strobe_o   <= 1'b0;
      adc_trig_o <= 1'b0;
    end else begin
      adc_trig_o <= 1'b0;
      pre_q      <= tick ? '0 : pre_q + PS_W'(1);
      if (tick) begin
        if (wrap) begin
          cnt      <= '0;
          per_act  <= per_w;
          cmpa_act <= cmpa_w;
          cmpb_act <= cmpb_w;
          strobe_o <= 1'b0;
        end else begin
          cnt <= cnt + CNT_W'(1);
          if ((cnt == cmpb_act) && !strobe_o) begin
            strobe_o   <= 1'b1;
            adc_trig_o <= trig_en;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dtpwm_deadtime.sv
module dtpwm_deadtime #(
  parameter int DT_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            cap_mode,
  input  logic            evt_on,
  input  logic            evt_off,
  input  logic [DT_W-1:0] dt,
  output logic            hs1_o,
  output logic            hs2_o
);
  import dtpwm_pkg::*;

  seq_e            st, nxt;
  logic [DT_W-1:0] dcnt, dn;

  always_comb begin
    nxt = st;
    dn  = dcnt;
    case (st)
      SQ_OFF: if (evt_on) begin
        nxt = (dt == '0) ? SQ_ON : SQ_LEAD;
        dn  = DT_W'(1);
      end
      SQ_LEAD: begin
        if (evt_off) begin
          nxt = (dt == '0) ? SQ_OFF : SQ_LAG;
          dn  = DT_W'(1);
        end else if (dcnt == dt) begin
          nxt = SQ_ON;
        end else begin
          dn = dcnt + DT_W'(1);
        end
      end
      SQ_ON: if (evt_off) begin
        nxt = (dt == '0) ? SQ_OFF : SQ_LAG;
        dn  = DT_W'(1);
      end
      default: begin
        if (dcnt == dt) nxt = SQ_OFF;
        else            dn  = dcnt + DT_W'(1);
      end
    endcase
    if (!run) begin
      nxt = SQ_OFF;
      dn  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SQ_OFF;
      dcnt  <= '0;
      hs1_o <= 1'b0;
      hs2_o <= 1'b0;
    end else begin
      st    <= nxt;
      dcnt  <= dn;
      hs1_o <= (nxt != SQ_OFF);
      hs2_o <= (nxt == SQ_ON) && !cap_mode;
    end
  end
endmodule

// File: rtl/dtpwm_capture.sv
module dtpwm_capture (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic cap_mode,
  input  logic cap_rise,
  input  logic pin_i,
  output logic cap_load
);
  logic [2:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], pin_i};
  end

  assign cap_load = run && cap_mode &&
                    (cap_rise ? (sync_q[1] && !sync_q[2]) : (!sync_q[1] && sync_q[2]));
endmodule

// File: rtl/dtpwm_timer.sv
module dtpwm_timer #(
  parameter int CNT_W = 12,
  parameter int DT_W  = 5,
  parameter int PS_W  = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       hs2_i,
  output logic       hs1_o,
  output logic       hs2_o,
  output logic       hs2_oe_o,
  output logic       strobe_o,
  output logic       adc_trig_o
);
  logic             run, cap_mode, cap_rise, trig_en, cap_load;
  logic [PS_W-1:0]  ps;
  logic [CNT_W-1:0] per_w, cmpa_w, cmpb_w, cnt, per_act;
  logic [DT_W-1:0]  dt;
  logic             evt_on, evt_off;

  dtpwm_regs #(.CNT_W(CNT_W), .DT_W(DT_W), .PS_W(PS_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_load(cap_load), .cap_value(cnt),
    .run(run), .cap_mode(cap_mode), .cap_rise(cap_rise), .trig_en(trig_en),
    .ps(ps), .per_w(per_w), .cmpa_w(cmpa_w), .cmpb_w(cmpb_w), .dt(dt)
  );

  dtpwm_counter #(.CNT_W(CNT_W), .PS_W(PS_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .cap_mode(cap_mode), .trig_en(trig_en),
    .ps(ps), .per_w(per_w), .cmpa_w(cmpa_w), .cmpb_w(cmpb_w),
    .cnt(cnt), .per_act(per_act), .evt_on(evt_on), .evt_off(evt_off),
    .strobe_o(strobe_o), .adc_trig_o(adc_trig_o)
  );

  dtpwm_deadtime #(.DT_W(DT_W)) u_seq (
    .clk(clk), .rst(rst), .run(run), .cap_mode(cap_mode),
    .evt_on(evt_on), .evt_off(evt_off), .dt(dt),
    .hs1_o(hs1_o), .hs2_o(hs2_o)
  );

  dtpwm_capture u_cap (
    .clk(clk), .rst(rst), .run(run), .cap_mode(cap_mode),
    .cap_rise(cap_rise), .pin_i(hs2_i), .cap_load(cap_load)
  );

  assign hs2_oe_o = !cap_mode;
endmodule

// File: rtl/dtpwm_timer_chk.sv
module dtpwm_timer_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             cap_mode,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] per_act,
  input logic             hs1_o,
  input logic             hs2_o,
  input logic             hs2_oe_o,
  input logic             strobe_o,
  input logic             adc_trig_o
);
  // R3: the count never passes the period in force
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (run && !cap_mode) |-> (cnt <= per_act));

  // R5: hs2 turns on only while hs1 is already on
  assert_lead_on_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(hs2_o) |-> hs1_o);

  // R6: hs1 turns off only once hs2 is off
  assert_lag_off_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(hs1_o) |-> !hs2_o);

  // R9: the trigger is a single-cycle pulse
  assert_trig_single_R9: assert property (@(posedge clk) disable iff (rst)
    adc_trig_o |=> !adc_trig_o);

  // R9: the trigger coincides with a fresh strobe rise
  assert_trig_with_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    adc_trig_o |-> (strobe_o && !$past(strobe_o)));

  // R11: stopping forces every output low
  assert_off_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!hs1_o && !hs2_o && !strobe_o && !adc_trig_o));

  // R12: a released HS2 pin is not driven
  assert_hs2_released_R12: assert property (@(posedge clk) disable iff (rst)
    (!hs2_oe_o && $past(!hs2_oe_o)) |-> !hs2_o);
endmodule

bind dtpwm_timer dtpwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .cap_mode(cap_mode), .cnt(cnt),
  .per_act(per_act), .hs1_o(hs1_o), .hs2_o(hs2_o), .hs2_oe_o(hs2_oe_o),
  .strobe_o(strobe_o), .adc_trig_o(adc_trig_o)
);

// File: tb/sim_dtpwm_timer.sv
module sim_dtpwm_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       hs2_i = 1'b0;
  logic       hs1_o, hs2_o, hs2_oe_o, strobe_o, adc_trig_o;

  int     checks = 0;
  int     errors = 0;
  longint cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dtpwm_timer u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hs2_i(hs2_i),
    .hs1_o(hs1_o), .hs2_o(hs2_o), .hs2_oe_o(hs2_oe_o),
    .strobe_o(strobe_o), .adc_trig_o(adc_trig_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_addr = 3'(a);
    @(negedge clk);
    d = int'(bus_rdata);
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0: return hs1_o;
      1: return hs2_o;
      default: return strobe_o;
    endcase
  endfunction

  task automatic wait_edge(input string req, input int sel, input bit rising, output longint t);
    logic prev;
    bit   ok;
    prev = sig(sel);
    ok   = 1'b0;
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (sig(sel) !== prev && sig(sel) === rising) begin ok = 1'b1; break; end
      prev = sig(sel);
    end
    t = cyc;
    if (!ok) check({req, " edge timeout"}, 0, 1);
  endtask

  task automatic setup_pwm(input int per, input int dt, input int ctrl);
    wr(0, 0);
    wr(1, per & 8'hFF); wr(2, per >> 8);
    wr(3, 10); wr(4, 0);
    wr(5, 20); wr(6, 0);
    wr(7, dt);
    wr(0, ctrl);
  endtask

  task automatic t_reset;
    int d;
    check("R1 hs1 low", hs1_o, 0);
    check("R1 hs2 low", hs2_o, 0);
    check("R1 strobe low", strobe_o, 0);
    check("R1 trigger low", adc_trig_o, 0);
    rd(0, d); check("R1 ctrl", d, 0);
    rd(1, d); check("R1 period lo", d, 8'hFF);
    rd(2, d); check("R1 period hi", d, 8'h0F);
    rd(4, d); check("R1 cmpa hi", d, 8'h0F);
    rd(5, d); check("R1 cmpb lo", d, 8'hFF);
    rd(7, d); check("R1 dead time", d, 8'h1F);
  endtask

  task automatic t_pwm_basic;
    longint t0, t1, t2, t3, t4, ts, tf;
    int d;
    setup_pwm(40, 3, 8'h09);
    rd(3, d); check("R2 cmpa readback", d, 10);
    wait_edge("R3", 0, 1, t0);
    wait_edge("R3", 0, 1, t1);
    check("R3 period ticks", t1 - t0, 41);
    wait_edge("R5", 1, 1, t2);
    check("R5 lead dead time", t2 - t1, 3);
    wait_edge("R6", 1, 0, t3);
    check("R6 hs2 off at period", t3 - t1, 30);
    wait_edge("R6", 0, 0, t4);
    check("R6 lag dead time", t4 - t3, 3);
    wait_edge("R8", 0, 1, t0);
    wait_edge("R8", 2, 1, ts);
    check("R8 strobe after cmpa", ts - t0, 10);
    check("R9 trigger with strobe", adc_trig_o, 1);
    @(negedge clk);
    check("R9 trigger one cycle", adc_trig_o, 0);
    wait_edge("R8", 2, 0, tf);
    check("R8 strobe width", tf - ts, 20);
  endtask

  task automatic t_no_trigger;
    int cnt_hi;
    int s_hi;
    wr(0, 8'h01);
    cnt_hi = 0; s_hi = 0;
    for (int i = 0; i < 82; i++) begin
      @(negedge clk);
      if (adc_trig_o) cnt_hi++;
      if (strobe_o) s_hi++;
    end
    check("R9 no trigger when disabled", cnt_hi, 0);
    check("R8 strobe still active", s_hi > 0, 1);
  endtask

  task automatic t_dead_locked;
    longint a, b;
    int d;
    wr(7, 7);
    rd(7, d); check("R10 dead time kept", d, 3);
    wait_edge("R10", 0, 1, a);
    wait_edge("R10", 1, 1, b);
    check("R10 gap unchanged", b - a, 3);
  endtask

  task automatic t_shadow;
    longint t0, t1, t2;
    int d;
    wait_edge("R7", 0, 1, t0);
    wr(1, 60);
    rd(1, d); check("R7 readback new period", d, 60);
    wait_edge("R7", 0, 1, t1);
    check("R7 old period holds", t1 - t0, 41);
    wait_edge("R7", 0, 1, t2);
    check("R7 new period at overflow", t2 - t1, 61);
  endtask

  task automatic t_stop;
    longint t;
    int hi;
    wait_edge("R11", 1, 1, t);
    wr(0, 0);
    @(negedge clk);
    check("R11 hs1 off", hs1_o, 0);
    check("R11 hs2 off", hs2_o, 0);
    check("R11 strobe off", strobe_o, 0);
    hi = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (hs1_o || hs2_o || strobe_o) hi++;
    end
    check("R11 stays off", hi, 0);
  endtask

  task automatic t_prescale;
    longint t0, t1, t2;
    setup_pwm(40, 3, 8'h31);
    wait_edge("R4", 0, 1, t0);
    wait_edge("R4", 0, 1, t1);
    check("R4 divided period", t1 - t0, 164);
    wait_edge("R4", 1, 1, t2);
    check("R4 dead time undivided", t2 - t1, 3);
  endtask

  task automatic t_dt_zero;
    longint t;
    setup_pwm(40, 0, 8'h01);
    wait_edge("R5", 0, 1, t);
    check("R5 zero dead time on", hs2_o, 1);
    wait_edge("R6", 1, 0, t);
    check("R6 zero dead time off", hs1_o, 0);
  endtask

  task automatic t_capture;
    longint n1, n2;
    int lo, hi, c1, c2;
    wr(0, 0);
    wr(0, 8'h07);
    @(negedge clk);
    @(negedge clk);
    check("R12 pin released", hs2_oe_o, 0);
    check("R12 hs2 low", hs2_o, 0);
    repeat (20) @(negedge clk);
    hs2_i = 1'b1; n1 = cyc;
    repeat (8) @(negedge clk);
    rd(1, lo); rd(2, hi); c1 = (hi << 8) | lo;
    hs2_i = 1'b0;
    repeat (8) @(negedge clk);
    rd(1, lo); rd(2, hi);
    check("R12 falling edge ignored", (hi << 8) | lo, c1);
    repeat (137) @(negedge clk);
    hs2_i = 1'b1; n2 = cyc;
    repeat (8) @(negedge clk);
    rd(1, lo); rd(2, hi); c2 = (hi << 8) | lo;
    check("R12 capture spacing", (c2 - c1 + 4096) % 4096, (n2 - n1) % 4096);
    wr(0, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pwm_basic();
    t_no_trigger();
    t_dead_locked();
    t_shadow();
    t_stop();
    t_prescale();
    t_dt_zero();
    t_capture();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule